// File: doc/BRIEF.md
# Adaptive Threshold Peak Detector

This block scans image rows one pixel per clock and marks bright ridges. Each pixel is first smoothed with its two horizontal neighbours. A smoothed pixel is reported as a peak when it rises above a detection threshold and is a local maximum within its row. The block emits one flag for every input pixel, a fixed number of cycles after that pixel arrives.

The threshold follows the scene's brightness. Selected rows are marked as sample rows. The block averages the raw intensity of each sample row and counts how many of four programmable reference levels lie below that average. The count, from 0 to 4, picks one of five programmable threshold values. The chosen value takes effect from the next row. Dark and bright scenes therefore each use a threshold suited to their contrast, with no software involvement per frame.

Top module: `adapt_peak_detector`

## Requirements
- R1: Each pixel is smoothed as s = floor((left + 2*centre + right) / 4), using raw pixels of the same row. The first pixel of a row uses itself as its left neighbour, and the last pixel uses itself as its right neighbour.
- R2: The flag for a pixel is 1 exactly when its smoothed value is strictly greater than the active threshold, greater than or equal to the smoothed value on its left, and strictly greater than the smoothed value on its right. Neighbours are replicated at the row edges in the same way as in R1, so the last pixel of a row is never flagged.
- R3: A row is 64 consecutive cycles with pix_valid high. peak_valid is high exactly two clock edges after each accepted pixel, once per pixel and in input order. A new row may start on the cycle right after the last pixel of the previous row, or after any idle gap.
- R4: A row is a sample row when row_sample is high together with its first pixel. Its average is floor(sum of its 64 raw pixels / 64). Rows that are not sample rows leave the band unchanged.
- R5: At the end of a sample row, the band becomes the number of reference fields k (ref_levels bits [8k+7:8k], k = 0..3) that the average is strictly greater than. An average equal to a reference does not count. The active threshold is the band_thr field at bits [8b+7:8b] for band b.
- R6: A band computed from a sample row applies from the first pixel of the row that follows it. The sample row itself is judged with the band that was in force before it.
- R7: After reset, peak_valid and peak_flag are 0, and band 2 is in force until the first sample row has completed.
- R8: row_sample is read only with the first pixel of a row. Its value on any other pixel has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_valid | input | 1 | A pixel is presented this cycle |
| pix_data | input | 8 | Raw pixel intensity |
| row_sample | input | 1 | Marks the current row as a sample row (read with its first pixel) |
| ref_levels | input | 32 | Four reference levels, field k at bits [8k+7:8k] |
| band_thr | input | 40 | Five threshold values, field b at bits [8b+7:8b] |
| peak_valid | output | 1 | peak_flag carries the result for one pixel |
| peak_flag | output | 1 | 1 when that pixel is a peak |

## Verification
The embedded assertions check these properties on every cycle:
- the two-edge alignment between accepted pixels and result strobes;
- that a smoothed value always lies between the smallest and largest of its three inputs;
- that the last pixel of a row is never flagged;
- that the pending band changes only at the end of a sample row;
- that the band in force changes only after a row's last result;
- that the latched sample marker changes only on a first pixel.

Only the bench's scenarios can show the rest:
- that each flag is correct against an independent model of smoothing and thresholding;
- which band a given average selects, including an average that exactly equals a reference level;
- that a sample row is itself judged with the previous band;
- that mid-row toggles of row_sample are ignored;
- that back-to-back rows and rows separated by gaps are handled alike.

// File: rtl/apd_pkg.sv
package apd_pkg;
  localparam int unsigned NUM_REFS   = 4;
  localparam int unsigned NUM_BANDS  = NUM_REFS + 1;
  localparam int unsigned BAND_W     = 3;
  localparam logic [BAND_W-1:0] RESET_BAND = 3'd2;

  // 1-2-1 kernel with floor divide by four
  function automatic int unsigned smooth3(int unsigned l, int unsigned c, int unsigned r);
    return (l + 2 * c + r) >> 2;
  endfunction

  // centre must clear the threshold, tie or beat the left, beat the right
  function automatic logic peak_test(int unsigned c, int unsigned l, int unsigned r,
                                     int unsigned thr);
    return (c > thr) && (c >= l) && (c > r);
  endfunction
endpackage

// File: rtl/apd_smooth_stage.sv
module apd_smooth_stage
  import apd_pkg::*;
#(
  parameter int PIX_W   = 8,
  parameter int ROW_LEN = 64,
  localparam int COL_W  = $clog2(ROW_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [PIX_W-1:0] in_pix,
  input  logic [COL_W-1:0] in_col,
  output logic             sm_fire,
  output logic [PIX_W-1:0] sm_val,
  output logic [COL_W-1:0] sm_col
);
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(ROW_LEN - 1);

  logic [PIX_W-1:0] x1, x2;
  logic             a_v;
  logic [COL_W-1:0] a_col;
  logic [PIX_W-1:0] left_px, right_px;

  always_comb begin
    sm_fire  = a_v && (in_valid || a_col == LAST_COL);
    left_px  = (a_col == '0) ? x1 : x2;
    right_px = (a_col == LAST_COL) ? x1 : in_pix;
    sm_val   = PIX_W'(smooth3(32'(left_px), 32'(x1), 32'(right_px)));
    sm_col   = a_col;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x1    <= '0;
      x2    <= '0;
      a_v   <= 1'b0;
      a_col <= '0;
    end else if (in_valid) begin
      x2    <= x1;
      x1    <= in_pix;
      a_v   <= 1'b1;
      a_col <= in_col;
    end else if (a_v && a_col == LAST_COL) begin
      a_v   <= 1'b0;
    end
  end

  AST_SMOOTH_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    sm_fire |-> ((sm_val <= x1 || sm_val <= left_px || sm_val <= right_px) &&
                 (sm_val >= x1 || sm_val >= left_px || sm_val >= right_px))); // R1
endmodule

// File: rtl/apd_level_tracker.sv
module apd_level_tracker
  import apd_pkg::*;
#(
  parameter int PIX_W   = 8,
  parameter int ROW_LEN = 64,
  localparam int COL_W  = $clog2(ROW_LEN),
  localparam int ACC_W  = PIX_W + COL_W + 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic [PIX_W-1:0]          in_pix,
  input  logic                      first_px,
  input  logic                      last_px,
  input  logic                      row_sample,
  input  logic [NUM_REFS*PIX_W-1:0] ref_levels,
  output logic [BAND_W-1:0]         band_pend
);
  logic             samp_q;
  logic [ACC_W-1:0] acc, acc_next;
  logic [PIX_W-1:0] avg;
  logic             in_samp;
  logic             sample_end;
  logic [NUM_REFS-1:0] above;

  always_comb begin
    in_samp    = first_px ? row_sample : samp_q;
    acc_next   = (first_px ? '0 : acc) + ACC_W'(in_pix);
    avg        = PIX_W'(acc_next / ACC_W'(ROW_LEN));
    sample_end = in_valid && last_px && in_samp;
  end

  for (genvar g = 0; g < NUM_REFS; g++) begin : g_ref
    assign above[g] = avg > ref_levels[g*PIX_W +: PIX_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q    <= 1'b0;
      acc       <= '0;
      band_pend <= RESET_BAND;
    end else if (in_valid) begin
      acc <= acc_next;
      if (first_px) samp_q <= row_sample;
      if (sample_end) band_pend <= BAND_W'($countones(above));
    end
  end

  AST_BAND_ONLY_AT_SAMPLE_END: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(band_pend) |-> $past(sample_end)); // R4
  AST_MARKER_ONLY_AT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(samp_q) |-> $past(in_valid && first_px)); // R8
endmodule

// File: rtl/apd_peak_stage.sv
module apd_peak_stage
  import apd_pkg::*;
#(
  parameter int PIX_W   = 8,
  parameter int ROW_LEN = 64,
  localparam int COL_W  = $clog2(ROW_LEN)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sm_fire,
  input  logic [PIX_W-1:0]           sm_val,
  input  logic [COL_W-1:0]           sm_col,
  input  logic [BAND_W-1:0]          band_pend,
  input  logic [NUM_BANDS*PIX_W-1:0] band_thr,
  output logic                       peak_valid,
  output logic                       peak_flag
);
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(ROW_LEN - 1);

  logic [PIX_W-1:0]  s1, s2;
  logic              b_v;
  logic [COL_W-1:0]  b_col;
  logic [BAND_W-1:0] band_act;
  logic [PIX_W-1:0]  lnb, rnb, thr;
  logic              pk_fire, hit, row_last_out;

  always_comb begin
    pk_fire      = b_v && (sm_fire || b_col == LAST_COL);
    lnb          = (b_col == '0) ? s1 : s2;
    rnb          = (b_col == LAST_COL) ? s1 : sm_val;
    thr          = band_thr[band_act*PIX_W +: PIX_W];
    hit          = peak_test(32'(s1), 32'(lnb), 32'(rnb), 32'(thr));
    row_last_out = pk_fire && b_col == LAST_COL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1         <= '0;
      s2         <= '0;
      b_v        <= 1'b0;
      b_col      <= '0;
      band_act   <= RESET_BAND;
      peak_valid <= 1'b0;
      peak_flag  <= 1'b0;
    end else begin
      peak_valid <= pk_fire;
      peak_flag  <= pk_fire && hit;
      if (sm_fire) begin
        s2    <= s1;
        s1    <= sm_val;
        b_v   <= 1'b1;
        b_col <= sm_col;
      end else if (b_v && b_col == LAST_COL) begin
        b_v   <= 1'b0;
      end
      if (row_last_out) band_act <= band_pend;
    end
  end

  AST_LAST_NEVER_PEAK: assert property (@(posedge clk) disable iff (!rst_n)
    row_last_out |=> !peak_flag); // R2
  AST_BAND_AT_ROW_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(band_act) |-> $past(row_last_out)); // R6
endmodule

// File: rtl/adapt_peak_detector.sv
module adapt_peak_detector
  import apd_pkg::*;
#(
  parameter int PIX_W   = 8,
  parameter int ROW_LEN = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       pix_valid,
  input  logic [PIX_W-1:0]           pix_data,
  input  logic                       row_sample,
  input  logic [NUM_REFS*PIX_W-1:0]  ref_levels,
  input  logic [NUM_BANDS*PIX_W-1:0] band_thr,
  output logic                       peak_valid,
  output logic                       peak_flag
);
  localparam int COL_W = $clog2(ROW_LEN);
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(ROW_LEN - 1);

  logic [COL_W-1:0]  col_cnt;
  logic              first_px, last_px;
  logic              sm_fire;
  logic [PIX_W-1:0]  sm_val;
  logic [COL_W-1:0]  sm_col;
  logic [BAND_W-1:0] band_pend;

  assign first_px = (col_cnt == '0);
  assign last_px  = (col_cnt == LAST_COL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         col_cnt <= '0;
    else if (pix_valid) col_cnt <= last_px ? '0 : col_cnt + 1'b1;
  end

  apd_smooth_stage #(.PIX_W(PIX_W), .ROW_LEN(ROW_LEN)) u_smooth (
    .clk(clk), .rst_n(rst_n), .in_valid(pix_valid), .in_pix(pix_data), .in_col(col_cnt),
    .sm_fire(sm_fire), .sm_val(sm_val), .sm_col(sm_col)
  );

  apd_level_tracker #(.PIX_W(PIX_W), .ROW_LEN(ROW_LEN)) u_level (
    .clk(clk), .rst_n(rst_n), .in_valid(pix_valid), .in_pix(pix_data),
    .first_px(first_px), .last_px(last_px), .row_sample(row_sample),
    .ref_levels(ref_levels), .band_pend(band_pend)
  );

  apd_peak_stage #(.PIX_W(PIX_W), .ROW_LEN(ROW_LEN)) u_peak (
    .clk(clk), .rst_n(rst_n), .sm_fire(sm_fire), .sm_val(sm_val), .sm_col(sm_col),
    .band_pend(band_pend), .band_thr(band_thr),
    .peak_valid(peak_valid), .peak_flag(peak_flag)
  );

  AST_RESULT_FOLLOWS_PIXEL: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pix_valid, 3) |-> peak_valid); // R3
  AST_NO_SPURIOUS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    peak_valid |-> $past(pix_valid, 3)); // R3
endmodule

// File: tb/adapt_peak_detector_tb_top.sv
module adapt_peak_detector_tb_top;
  localparam int PW = 8;
  localparam int RL = 64;

  typedef struct {
    bit    flag;
    int    cyc;
    int    row;
    int    col;
    string req;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pix_valid = 1'b0;
  logic [PW-1:0] pix_data = '0;
  logic          row_sample = 1'b0;
  logic [4*PW-1:0] ref_levels = {8'd160, 8'd120, 8'd80, 8'd40};
  logic [5*PW-1:0] band_thr   = {8'd180, 8'd140, 8'd100, 8'd60, 8'd20};
  logic          peak_valid, peak_flag;

  int   checks = 0;
  int   errors = 0;
  int   cyc = 0;
  int   row_no = 0;
  int   band_m = 2;
  bit [15:0] lfsr = 16'hACE1;
  int   px[RL];
  exp_t sb[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  adapt_peak_detector #(.PIX_W(PW), .ROW_LEN(RL)) dut_i (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_data(pix_data),
    .row_sample(row_sample), .ref_levels(ref_levels), .band_thr(band_thr),
    .peak_valid(peak_valid), .peak_flag(peak_flag)
  );

  function automatic int nxt_rand();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return int'(lfsr[7:0]);
  endfunction

  // kinds: 0 dark spikes, 1 bright spikes, 2 flat 80, 3 flat 0, 4 flat 255,
  // 5 plateaus, 6 random
  task automatic build_row(input int kind);
    for (int i = 0; i < RL; i++) begin
      case (kind)
        0: px[i] = 10;
        1: px[i] = 125;
        2: px[i] = 80;
        3: px[i] = 0;
        4: px[i] = 255;
        5: px[i] = 30;
        default: px[i] = nxt_rand();
      endcase
    end
    if (kind <= 1) begin
      for (int k = 0; k < 10; k++) px[4 + 6*k] = (30 + 24*k > 255) ? 255 : 30 + 24*k;
      px[0] = 250;
      px[RL-1] = 250;
    end
    if (kind == 5) begin
      px[10] = 200; px[11] = 200;
      px[20] = 150; px[21] = 150; px[22] = 150;
      px[40] = 240; px[41] = 120; px[42] = 240;
      px[62] = 220; px[63] = 220;
    end
  endtask

  function automatic int clampi(int i);
    return (i < 0) ? 0 : ((i > RL-1) ? RL-1 : i);
  endfunction

  task automatic send_row(input int kind, input bit samp_first, input bit samp_rest,
                          input int gap, input string req);
    int sm[RL];
    bit fl[RL];
    int thr, sum, avg, nb;
    build_row(kind);
    for (int i = 0; i < RL; i++)
      sm[i] = (px[clampi(i-1)] + px[i] + px[i] + px[clampi(i+1)]) / 4;
    thr = int'(band_thr[band_m*PW +: PW]);
    for (int i = 0; i < RL; i++)
      fl[i] = (sm[i] > thr) && (sm[i] >= sm[clampi(i-1)]) && (sm[i] > sm[clampi(i+1)]);
    for (int i = 0; i < RL; i++) begin
      exp_t e;
      @(negedge clk);
      pix_valid  = 1'b1;
      pix_data   = PW'(px[i]);
      row_sample = (i == 0) ? samp_first : samp_rest;
      e.flag = fl[i]; e.cyc = cyc + 3; e.row = row_no; e.col = i; e.req = req;
      sb.push_back(e);
    end
    if (samp_first) begin
      sum = 0;
      for (int i = 0; i < RL; i++) sum += px[i];
      avg = sum / RL;
      nb = 0;
      for (int k = 0; k < 4; k++) if (avg > int'(ref_levels[k*PW +: PW])) nb++;
      band_m = nb;
    end
    row_no++;
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      pix_valid = 1'b0;
      row_sample = 1'b0;
    end
  endtask

  // monitor: compare each result strobe with the oldest expected item
  always @(negedge clk) begin
    if (rst_n && peak_valid) begin
      if (sb.size() == 0) begin
        checks++; errors++;
        $display("FAIL R3 unexpected result strobe: got 1 exp 0");
      end else begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (peak_flag !== e.flag) begin
          errors++;
          $display("FAIL %s row %0d col %0d flag: got %0b exp %0b",
                   e.req, e.row, e.col, peak_flag, e.flag);
        end
        checks++;
        if (cyc != e.cyc) begin
          errors++;
          $display("FAIL R3 row %0d col %0d timing: got cycle %0d exp %0d",
                   e.row, e.col, cyc, e.cyc);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired: got hang exp completion");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    checks++;
    if (peak_valid !== 1'b0 || peak_flag !== 1'b0) begin
      errors++;
      $display("FAIL R7 outputs in reset: got %0b%0b exp 00", peak_valid, peak_flag);
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    checks++;
    if (peak_valid !== 1'b0) begin
      errors++;
      $display("FAIL R7 idle after reset: got %0b exp 0", peak_valid);
    end
    send_row(0, 0, 0, 3, "R7 R2 band2");          // reset band in force
    send_row(1, 1, 1, 0, "R6 R1 old band");       // sample row judged with old band
    send_row(0, 0, 0, 2, "R5 R6 band3");          // new band from next row
    send_row(4, 0, 1, 1, "R8 late marker");       // marker after first pixel ignored
    send_row(0, 0, 0, 0, "R8 R4 band kept");
    send_row(2, 1, 0, 5, "R5 equal ref");         // avg 80 equals a reference -> band 1
    send_row(0, 0, 0, 0, "R5 band1");
    send_row(3, 1, 1, 0, "R4 dark sample");       // band 0, back to back
    send_row(0, 0, 0, 1, "R5 band0");
    send_row(4, 1, 1, 0, "R4 bright sample");     // band 4
    send_row(6, 0, 0, 0, "R2 random band4");
    send_row(5, 0, 0, 2, "R2 R1 plateaus");
    send_row(6, 1, 0, 0, "R4 random sample");
    send_row(6, 0, 0, 0, "R2 R6 random");
    send_row(1, 0, 0, 4, "R2 spikes");
    pix_valid = 1'b0;
    repeat (10) @(negedge clk);
    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R3 missing results: got %0d pending exp 0", sb.size());
    end
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule